// File: doc/BRIEF.md
# I/O Port to Memory Window Bridge

This block sits between a host that issues I/O port accesses and a bus that only understands memory-mapped transactions. Each host request names a 16-bit port number, a direction and a width of one, two or four bytes. The bridge turns the port number into a 32-bit address inside a fixed window. It converts the data between host byte order and the little-endian order of the bus. It then issues a single memory transaction and returns the completion to the host.

The address rule has two cases. Ports whose bits 9 and 8 are both clear appear in the window unchanged. Any other port is scattered so that its upper, middle and lowest bit groups land in separate address fields. A bus-present input gates all traffic. When it is low, nothing reaches the memory side. Reads then finish at once with an all-ones value of the requested width, and writes are discarded.

The host may have only one request open at a time. A request is taken only while the bridge is idle. The memory side carries one transaction at a time, and for reads the data returns as a separate pulse.

Top module: `pwb_port_bridge`

## Requirements
- R1: Every address driven on `m_addr` while `m_valid` is high has bits 31:26 all set and bits 25:19 clear (window base 0xFC000000).
- R2: When port bits 9:8 are both zero, `m_addr` equals 0xFC000000 OR'd with the 16-bit port value.
- R3: When port bit 9 or bit 8 is set, `m_addr` holds port bits 2:0 at address bits 2:0, port bits 9:3 at address bits 18:12, and port bits 15:10 at address bits 9:4. All other bits below 26 are zero.
- R4: Size code 0 is one byte, 1 is two bytes, and 2 is four bytes. Byte data uses bits 7:0 unchanged. Two-byte data swaps bits 15:8 and 7:0. Four-byte data reverses all four bytes. Lanes above the access width are zero. The same conversion applies to write data toward the bus and to read data toward the host.
- R5: With `bus_present` low, an accepted read raises `h_ready` one cycle later. `h_rdata` is then 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for sizes 0, 1 and 2.
- R6: With `bus_present` low, an accepted write never raises `m_valid` and raises `h_ready` one cycle later.
- R7: `h_ready` is high for exactly one cycle per request. For a write it rises the cycle after `m_valid` and `m_ready` are both high. For a read it rises the cycle after `m_rvalid`, which is only honoured after the request has been accepted.
- R8: `m_valid` rises the cycle after an accepted request. It stays high with stable `m_addr`, `m_we`, `m_size` and `m_wdata` until `m_ready`. `h_req` is ignored while a request is open, and `m_valid` and `h_ready` are never high together.
- R9: A synchronous active-high `rst` drops `m_valid` and `h_ready` and abandons any open request. The bridge accepts a fresh request afterwards.
- R10: Size code 3 is handled as a four-byte access and is presented on `m_size` as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_present | input | 1 | High when the memory-side bus exists |
| h_req | input | 1 | Host request strobe, taken while idle |
| h_we | input | 1 | Host direction, 1 for write |
| h_size | input | 2 | Access width code |
| h_port | input | 16 | Port number |
| h_wdata | input | 32 | Host write data, host order |
| h_ready | output | 1 | One-cycle completion pulse |
| h_rdata | output | 32 | Read data, host order |
| m_valid | output | 1 | Memory request valid |
| m_ready | input | 1 | Memory request accepted |
| m_addr | output | 32 | Window address |
| m_we | output | 1 | Memory direction, 1 for write |
| m_size | output | 2 | Normalised width code |
| m_wdata | output | 32 | Write data, bus order |
| m_rvalid | input | 1 | Read data valid pulse |
| m_rdata | input | 32 | Read data, bus order |

## Verification
Four properties are checked on every cycle: the fixed window base bits, the hold of a stalled memory request, the single-cycle completion pulse, and the separation of memory requests from completions. The fast completion and the absence of memory traffic when the bus is absent are also checked continuously. Only the bench scenarios can show the exact scattered and direct address for each port, the byte-lane conversion for each width, and the recovery after a reset that lands mid-transfer. The bench sweeps thousands of ports and many data patterns for these.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_RD,
        ST_DONE
    } seq_state_e;

    localparam logic [31:0] WIN_BASE = 32'hFC00_0000;

    // Reserved width code behaves as a full word.
    function automatic xfer_size_e norm_size(input logic [1:0] code);
        xfer_size_e s;
        case (code)
            2'd0:    s = SZ_BYTE;
            2'd1:    s = SZ_HALF;
            default: s = SZ_WORD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwb_addr_map.sv
module pwb_addr_map
    import pwb_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int ADDR_W = 32
) (
    input  logic [PORT_W-1:0] port,
    output logic [ADDR_W-1:0] addr
);
    localparam int LOW_GRP = 3;    // bits kept in place
    localparam int MID_TOP = 10;   // first bit of the upper group
    localparam int MID_SHL = 9;    // shift of the middle group
    localparam int HI_SHR  = 6;    // shift of the upper group

    logic [ADDR_W-1:0] scattered;
    logic              split;

    assign split = port[9] | port[8];

    always_comb begin
        scattered = '0;
        for (int b = 0; b < PORT_W; b++) begin
            if (b < LOW_GRP)
                scattered[b] = port[b];
            else if (b < MID_TOP)
                scattered[b + MID_SHL] = port[b];
            else
                scattered[b - HI_SHR] = port[b];
        end
    end

    always_comb begin
        if (split)
            addr = WIN_BASE[ADDR_W-1:0] | scattered;
        else
            addr = WIN_BASE[ADDR_W-1:0] | {{(ADDR_W-PORT_W){1'b0}}, port};
    end

endmodule

// File: rtl/pwb_lane_swap.sv
module pwb_lane_swap
    import pwb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  xfer_size_e        size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int LANES = DATA_W / 8;

    always_comb begin
        dout = '0;
        case (size)
            SZ_BYTE: dout[7:0] = din[7:0];
            SZ_HALF: begin
                dout[7:0]  = din[15:8];
                dout[15:8] = din[7:0];
            end
            default: begin
                for (int i = 0; i < LANES; i++)
                    dout[8*i +: 8] = din[8*(LANES-1-i) +: 8];
            end
        endcase
    end

endmodule

// File: rtl/pwb_seq.sv
module pwb_seq
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_present,
    input  logic              h_req,
    input  logic              h_we,
    input  xfer_size_e        size_n,
    input  logic [ADDR_W-1:0] win_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] absent_fill,
    input  logic [DATA_W-1:0] host_rd,
    input  logic              m_ready,
    input  logic              m_rvalid,
    output logic              h_ready,
    output logic [DATA_W-1:0] h_rdata,
    output logic              m_valid,
    output logic [ADDR_W-1:0] m_addr,
    output logic              m_we,
    output xfer_size_e        m_size,
    output logic [DATA_W-1:0] m_wdata,
    output logic              busy
);
    seq_state_e        st;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              we_q;
    xfer_size_e        size_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            we_q    <= 1'b0;
            size_q  <= SZ_BYTE;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (h_req) begin
                        we_q    <= h_we;
                        size_q  <= size_n;
                        addr_q  <= win_addr;
                        wdata_q <= bus_wdata;
                        if (bus_present) begin
                            st <= ST_ISSUE;
                        end else begin
                            st <= ST_DONE;
                            if (!h_we)
                                rdata_q <= absent_fill;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (m_ready)
                        st <= we_q ? ST_DONE : ST_WAIT_RD;
                end
                ST_WAIT_RD: begin
                    if (m_rvalid) begin
                        rdata_q <= host_rd;
                        st      <= ST_DONE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign h_ready = (st == ST_DONE);
    assign m_valid = (st == ST_ISSUE);
    assign busy    = (st != ST_IDLE);
    assign h_rdata = rdata_q;
    assign m_addr  = addr_q;
    assign m_we    = we_q;
    assign m_size  = size_q;
    assign m_wdata = wdata_q;

endmodule

// File: rtl/pwb_port_bridge.sv
module pwb_port_bridge
    import pwb_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_present,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [1:0]        h_size,
    input  logic [PORT_W-1:0] h_port,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_ready,
    output logic [DATA_W-1:0] h_rdata,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [ADDR_W-1:0] m_addr,
    output logic              m_we,
    output logic [1:0]        m_size,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_rvalid,
    input  logic [DATA_W-1:0] m_rdata
);
    xfer_size_e        size_n;
    xfer_size_e        size_q;
    logic [ADDR_W-1:0] win_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] host_rd;
    logic [DATA_W-1:0] absent_fill;
    logic              busy;

    assign size_n = norm_size(h_size);

    always_comb begin
        absent_fill = '0;
        case (size_n)
            SZ_BYTE: absent_fill[7:0]  = '1;
            SZ_HALF: absent_fill[15:0] = '1;
            default: absent_fill       = '1;
        endcase
    end

    pwb_addr_map #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_map (
        .port (h_port),
        .addr (win_addr)
    );

    pwb_lane_swap #(.DATA_W(DATA_W)) u_wr_swap (
        .size (size_n),
        .din  (h_wdata),
        .dout (bus_wdata)
    );

    pwb_lane_swap #(.DATA_W(DATA_W)) u_rd_swap (
        .size (size_q),
        .din  (m_rdata),
        .dout (host_rd)
    );

    pwb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .bus_present (bus_present),
        .h_req       (h_req),
        .h_we        (h_we),
        .size_n      (size_n),
        .win_addr    (win_addr),
        .bus_wdata   (bus_wdata),
        .absent_fill (absent_fill),
        .host_rd     (host_rd),
        .m_ready     (m_ready),
        .m_rvalid    (m_rvalid),
        .h_ready     (h_ready),
        .h_rdata     (h_rdata),
        .m_valid     (m_valid),
        .m_addr      (m_addr),
        .m_we        (m_we),
        .m_size      (size_q),
        .m_wdata     (m_wdata),
        .busy        (busy)
    );

    assign m_size = size_q;

endmodule

// File: rtl/pwb_port_bridge_chk.sv
module pwb_port_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_present,
    input logic              h_req,
    input logic              h_ready,
    input logic              m_valid,
    input logic              m_ready,
    input logic              m_we,
    input logic [1:0]        m_size,
    input logic [ADDR_W-1:0] m_addr,
    input logic [DATA_W-1:0] m_wdata,
    input logic              busy
);
    a_r1_window_base: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (m_addr[31:26] == 6'h3F && m_addr[25:19] == 7'h00));

    a_r5_absent_read_fast: assert property (@(posedge clk) disable iff (rst)
        (h_req && !busy && !bus_present) |=> h_ready);

    a_r6_absent_no_mem: assert property (@(posedge clk) disable iff (rst)
        (h_req && !busy && !bus_present) |=> !m_valid);

    a_r7_ready_single: assert property (@(posedge clk) disable iff (rst)
        h_ready |=> !h_ready);

    a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_we)
                                   && $stable(m_size) && $stable(m_wdata)));

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(m_valid && h_ready));

endmodule

bind pwb_port_bridge pwb_port_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_present (bus_present),
    .h_req       (h_req),
    .h_ready     (h_ready),
    .m_valid     (m_valid),
    .m_ready     (m_ready),
    .m_we        (m_we),
    .m_size      (m_size),
    .m_addr      (m_addr),
    .m_wdata     (m_wdata),
    .busy        (busy)
);

// File: tb/pwb_port_bridge_tb.sv
module pwb_port_bridge_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_present = 1'b0;
    logic        h_req = 1'b0;
    logic        h_we = 1'b0;
    logic [1:0]  h_size = 2'd0;
    logic [15:0] h_port = 16'd0;
    logic [31:0] h_wdata = 32'd0;
    logic        h_ready;
    logic [31:0] h_rdata;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic [31:0] m_addr;
    logic        m_we;
    logic [1:0]  m_size;
    logic [31:0] m_wdata;
    logic        m_rvalid = 1'b0;
    logic [31:0] m_rdata = 32'd0;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwb_port_bridge u_dut (
        .clk(clk), .rst(rst), .bus_present(bus_present),
        .h_req(h_req), .h_we(h_we), .h_size(h_size), .h_port(h_port),
        .h_wdata(h_wdata), .h_ready(h_ready), .h_rdata(h_rdata),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_we(m_we),
        .m_size(m_size), .m_wdata(m_wdata), .m_rvalid(m_rvalid), .m_rdata(m_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // R2/R3 expected address, built bit by bit
    function automatic logic [31:0] exp_addr(input logic [15:0] p);
        logic [31:0] a;
        a = 32'hFC00_0000;
        if (p[9] || p[8]) begin
            for (int b = 0; b < 16; b++) begin
                if (b < 3)       a[b]     = p[b];
                else if (b < 10) a[b + 9] = p[b];
                else             a[b - 6] = p[b];
            end
        end else begin
            a = a + {16'd0, p};
        end
        return a;
    endfunction

    // R4 lane conversion
    function automatic logic [31:0] exp_conv(input logic [1:0] s, input logic [31:0] d);
        case (s)
            2'd0:    return {24'd0, d[7:0]};
            2'd1:    return {16'd0, d[7:0], d[15:8]};
            default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
        endcase
    endfunction

    function automatic logic [31:0] exp_fill(input logic [1:0] s);
        case (s)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic access(input logic we, input logic [1:0] sz, input logic [15:0] port,
                          input logic [31:0] wd, input logic [31:0] md, input int lat,
                          input bit poke);
        logic [31:0] ea;
        logic [1:0]  es;
        ea = exp_addr(port);
        es = (sz == 2'd3) ? 2'd2 : sz;
        @(negedge clk);
        h_req = 1'b1; h_we = we; h_size = sz; h_port = port; h_wdata = wd;
        @(negedge clk);
        h_req = 1'b0;
        if (!bus_present) begin
            chk(we ? "R6 absent write ready" : "R5 absent read ready", {31'd0, h_ready}, 32'd1);
            chk("R6 no memory request when absent", {31'd0, m_valid}, 32'd0);
            if (!we) chk("R5 absent fill", h_rdata, exp_fill(es));
            @(negedge clk);
            chk("R7 ready single cycle", {31'd0, h_ready}, 32'd0);
            chk("R6 still no memory request", {31'd0, m_valid}, 32'd0);
        end else begin
            chk("R8 valid after accept", {31'd0, m_valid}, 32'd1);
            chk((port[9] || port[8]) ? "R3 scattered address" : "R2 direct address", m_addr, ea);
            chk("R1 window base", {26'd0, m_addr[31:26]}, 32'h3F);
            chk("R8 direction", {31'd0, m_we}, {31'd0, we});
            chk("R10 size code", {30'd0, m_size}, {30'd0, es});
            if (we) chk("R4 write lanes", m_wdata, exp_conv(es, wd));
            for (int k = 0; k < lat; k++) begin
                if (poke) begin
                    h_req = 1'b1; h_port = ~port; h_we = ~we;
                end
                @(negedge clk);
                h_req = 1'b0;
                chk("R8 held address", m_addr, ea);
                chk("R8 held valid", {31'd0, m_valid}, 32'd1);
            end
            m_ready = 1'b1;
            @(negedge clk);
            m_ready = 1'b0;
            if (we) begin
                chk("R7 write completes after accept", {31'd0, h_ready}, 32'd1);
            end else begin
                chk("R7 read waits for data", {31'd0, h_ready}, 32'd0);
                chk("R8 valid drops after accept", {31'd0, m_valid}, 32'd0);
                m_rvalid = 1'b1; m_rdata = md;
                @(negedge clk);
                m_rvalid = 1'b0;
                chk("R7 read completes after data", {31'd0, h_ready}, 32'd1);
                chk("R4 read lanes", h_rdata, exp_conv(es, md));
            end
            @(negedge clk);
            chk("R7 ready single cycle", {31'd0, h_ready}, 32'd0);
            chk("R8 no extra request", {31'd0, m_valid}, 32'd0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R9: reset with request held high
        rst = 1'b1; h_req = 1'b1; bus_present = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 ready low in reset", {31'd0, h_ready}, 32'd0);
        chk("R9 valid low in reset", {31'd0, m_valid}, 32'd0);
        h_req = 1'b0; rst = 1'b0;
        @(negedge clk);
        chk("R9 ready low after reset", {31'd0, h_ready}, 32'd0);
        chk("R9 valid low after reset", {31'd0, m_valid}, 32'd0);

        // R2/R3 corner ports
        access(1'b0, 2'd0, 16'h0000, 32'd0, 32'h11, 0, 1'b0);
        access(1'b0, 2'd0, 16'hFFFF, 32'd0, 32'h22, 0, 1'b0);
        access(1'b0, 2'd0, 16'hFCFF, 32'd0, 32'h33, 1, 1'b0);
        access(1'b0, 2'd0, 16'h0100, 32'd0, 32'h44, 0, 1'b0);
        access(1'b0, 2'd0, 16'h0200, 32'd0, 32'h55, 0, 1'b0);
        access(1'b1, 2'd0, 16'h0007, 32'hA5, 32'd0, 0, 1'b0);

        // R2/R3 sweep across the port space
        for (int i = 0; i < 4096; i++)
            access(i[0], 2'd0, 16'(i * 16 + (i % 16)), 32'(i), 32'(i * 3), i % 3, 1'b0);

        // R4/R10 data patterns for every width code and direction
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++)
                for (int j = 0; j < 64; j++)
                    access(w[0], 2'(s), 16'(j * 997), 32'(j * 32'h9E37_79B9) ^ 32'h0F1E_2D3C,
                           32'(j * 32'h6D2B_79F5) ^ 32'hC3A5_5A3C, j % 2, 1'b0);

        // R8 requests while busy are ignored
        for (int j = 0; j < 8; j++)
            access(j[0], 2'd2, 16'(16'h0300 + j), 32'h0102_0304, 32'hA1B2_C3D4, 3, 1'b1);

        // R5/R6 bus absent
        bus_present = 1'b0;
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++)
                for (int j = 0; j < 16; j++)
                    access(w[0], 2'(s), 16'(j * 4099), 32'hDEAD_BEEF, 32'd0, 0, 1'b0);

        // R9 reset in the middle of a transfer
        bus_present = 1'b1;
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b0; h_size = 2'd2; h_port = 16'h0321;
        @(negedge clk);
        h_req = 1'b0;
        chk("R9 request open before reset", {31'd0, m_valid}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 request abandoned", {31'd0, m_valid}, 32'd0);
        chk("R9 no completion", {31'd0, h_ready}, 32'd0);
        access(1'b0, 2'd1, 16'h0321, 32'd0, 32'h0000_BEEF, 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule